// File: doc/BRIEF.md
# Dual-Calendar FIFO Status Scheduler

This block produces the transmit half of a FIFO status channel in the style of SPI-4.2. It puts out one 2-bit status word on every status clock cycle.

The block works in calendar passes. A pass sends:

- a framing word;
- one status word for each calendar entry, with that entry's 2-bit status taken live from a per-port status vector;
- a closing 2-bit parity word.

Bursts of a fixed training pattern come between passes. A burst is sent right after the block is enabled. After that, a burst is sent every time a programmed number of passes has completed.

Two calendars are held in local storage, and a write port loads them. The calendar that a pass uses is picked by a switch-enable bit and a select bit. The choice is latched at the framing word, so the calendar never changes in the middle of a pass. An enable bit keeps the block idle after reset and while it is being set up.

Top module: `fstat_sched`

## Requirements
- R1: When reset is held, and on every cycle in the idle state, `stat_out` is 2'b11. The block stays idle while `cfg_enable` is 0.
- R2: A training repetition is TRAIN_HALF words of 2'b11 followed by TRAIN_HALF words of 2'b00 (TRAIN_HALF = 10 by default). A burst holds `cfg_repeat`+1 repetitions.
- R3: A pass is one framing word 2'b11, then one word per calendar entry in ascending entry order, then one parity word. A pass follows a burst or another pass directly.
- R4: The word for entry i is `port_status[2p+1:2p]`, where p is the port number stored in entry i of the active calendar. It is taken in the same cycle that the word is sent.
- R5: The parity word is the bitwise inverse of the XOR of all entry words of that pass.
- R6: A pass uses calendar 0 when `cfg_cal_sw_en` is 0, whatever `cfg_cal_sel` holds. When `cfg_cal_sw_en` is 1, `cfg_cal_sel` picks calendar 0 (value 0) or calendar 1 (value 1).
- R7: The calendar choice, and the length of the chosen calendar, are sampled only in the framing-word cycle. Changes during a pass do not affect that pass.
- R8: When `cfg_interval` N is nonzero, a burst follows the parity word of every Nth pass, counted since the last burst. When N is 0, no burst comes after the initial one.
- R9: Clearing `cfg_enable` returns the block to idle on the next cycle and clears the pass count. Setting it again starts with a fresh initial burst.
- R10: A calendar length field holding L gives L+1 entries per pass, from 1 up to CAL_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Scheduling enable |
| cfg_interval | input | INT_W | Passes between training bursts; 0 means no periodic bursts |
| cfg_repeat | input | REP_W | Repetitions per burst, minus one |
| cfg_cal_sw_en | input | 1 | Allows calendar 1 to be used |
| cfg_cal_sel | input | 1 | Calendar choice when switching is allowed |
| cfg_len0 | input | AW | Calendar 0 entry count minus one |
| cfg_len1 | input | AW | Calendar 1 entry count minus one |
| cal_wr_en | input | 1 | Calendar entry write strobe |
| cal_wr_sel | input | 1 | Calendar being written |
| cal_wr_addr | input | AW | Entry index being written |
| cal_wr_port | input | PORT_W | Port number stored in the entry |
| port_status | input | 2*NPORTS | 2-bit status per port, port p at bits 2p+1:2p |
| stat_out | output | 2 | Status word for this cycle |

## Verification
Every internal counter error shows up in the output stream within one pass or one training repetition:

- A sequencing fault puts a framing word, training word or parity word where the reference stream expects something else, on the very cycle the fault occurs.
- A wrong latched calendar or length shows up as wrong entry words, or a misplaced parity word, in the pass that follows the framing word.
- A parity accumulator fault shows up at the end of the same pass.
- A pass-count error shifts the next burst by at least one pass.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
   typedef enum logic [2:0] {
      S_OFF   = 3'd0,
      S_TRAIN = 3'd1,
      S_FRAME = 3'd2,
      S_ENTRY = 3'd3,
      S_DIP   = 3'd4
   } fstat_state_e;

   localparam logic [1:0] FRAME_CODE = 2'b11;
   localparam logic [1:0] TRAIN_LO   = 2'b00;
endpackage

// File: rtl/fstat_cal_store.sv
module fstat_cal_store #(
   parameter int DEPTH  = 256,
   parameter int PORT_W = 4,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [AW-1:0]     wr_addr,
   input  logic [PORT_W-1:0] wr_port,
   input  logic              rd_sel,
   input  logic [AW-1:0]     rd_addr,
   output logic [PORT_W-1:0] rd_port
);
   logic [PORT_W-1:0] rd_bank [2];

   for (genvar c = 0; c < 2; c++) begin : g_bank
      logic [PORT_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_sel == c[0])) begin
            mem[wr_addr] <= wr_port;
         end
      end
      assign rd_bank[c] = mem[rd_addr];
   end

   assign rd_port = rd_sel ? rd_bank[1] : rd_bank[0];
endmodule

// File: rtl/fstat_parity.sv
module fstat_parity #(
   parameter bit ODD = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       add,
   input  logic [1:0] word_in,
   output logic [1:0] dip
);
   logic [1:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= 2'b00;
      end else if (clr) begin
         acc <= 2'b00;
      end else if (add) begin
         acc <= acc ^ word_in;
      end
   end

   if (ODD) begin : g_odd
      assign dip = ~acc;
   end else begin : g_even
      assign dip = acc;
   end

   // R5
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == 2'b00));
endmodule

// File: rtl/fstat_seq.sv
module fstat_seq
   import fstat_pkg::*;
#(
   parameter int AW         = 8,
   parameter int INT_W      = 24,
   parameter int REP_W      = 8,
   parameter int TRAIN_HALF = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [INT_W-1:0] interval,
   input  logic [REP_W-1:0] repeat_m1,
   input  logic             sw_en,
   input  logic             sel,
   input  logic [AW-1:0]    len0,
   input  logic [AW-1:0]    len1,
   output fstat_state_e     st,
   output logic             train_hi,
   output logic [AW-1:0]    idx,
   output logic             act_cal
);
   localparam int TW = $clog2(2 * TRAIN_HALF);
   localparam logic [TW-1:0] W_LAST = TW'(2 * TRAIN_HALF - 1);
   localparam logic [TW-1:0] W_HALF = TW'(TRAIN_HALF);

   logic [TW-1:0]    wcnt;
   logic [REP_W-1:0] rep;
   logic [INT_W-1:0] pass;
   logic [AW-1:0]    len_q;
   logic [INT_W:0]   pass_nx;
   logic             pick;

   assign pass_nx  = {1'b0, pass} + 1'b1;
   assign pick     = sw_en & sel;
   assign train_hi = (wcnt < W_HALF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_OFF;
         wcnt    <= '0;
         rep     <= '0;
         pass    <= '0;
         idx     <= '0;
         len_q   <= '0;
         act_cal <= 1'b0;
      end else if (!en) begin
         st   <= S_OFF;
         pass <= '0;
      end else begin
         unique case (st)
            S_OFF: begin
               st   <= S_TRAIN;
               rep  <= '0;
               wcnt <= '0;
            end
            S_TRAIN: begin
               if (wcnt == W_LAST) begin
                  wcnt <= '0;
                  if (rep >= repeat_m1) st <= S_FRAME;
                  else                  rep <= rep + 1'b1;
               end else begin
                  wcnt <= wcnt + 1'b1;
               end
            end
            S_FRAME: begin
               act_cal <= pick;
               len_q   <= pick ? len1 : len0;
               idx     <= '0;
               st      <= S_ENTRY;
            end
            S_ENTRY: begin
               if (idx == len_q) st  <= S_DIP;
               else              idx <= idx + 1'b1;
            end
            S_DIP: begin
               if (interval == '0) begin
                  pass <= '0;
                  st   <= S_FRAME;
               end else if (pass_nx >= {1'b0, interval}) begin
                  pass <= '0;
                  rep  <= '0;
                  wcnt <= '0;
                  st   <= S_TRAIN;
               end else begin
                  pass <= pass_nx[INT_W-1:0];
                  st   <= S_FRAME;
               end
            end
            default: st <= S_OFF;
         endcase
      end
   end

   // R9
   drop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (st == S_OFF));

   // R3
   frame_then_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && st == S_FRAME) |=> (st == S_ENTRY));

   // R8
   no_retrain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && st == S_DIP && interval == '0) |=> (st == S_FRAME));

   // R7
   cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ENTRY) |=> (st != S_ENTRY || ($stable(act_cal) && $stable(len_q))));

   // R10
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ENTRY) |-> (idx <= len_q));

   // R2
   train_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_TRAIN) |-> (wcnt <= W_LAST));
endmodule

// File: rtl/fstat_sched.sv
module fstat_sched
   import fstat_pkg::*;
#(
   parameter int NPORTS     = 16,
   parameter int CAL_DEPTH  = 256,
   parameter int INT_W      = 24,
   parameter int REP_W      = 8,
   parameter int TRAIN_HALF = 10,
   parameter bit ODD_DIP    = 1'b1,
   localparam int PORT_W    = $clog2(NPORTS),
   localparam int AW        = $clog2(CAL_DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_enable,
   input  logic [INT_W-1:0]    cfg_interval,
   input  logic [REP_W-1:0]    cfg_repeat,
   input  logic                cfg_cal_sw_en,
   input  logic                cfg_cal_sel,
   input  logic [AW-1:0]       cfg_len0,
   input  logic [AW-1:0]       cfg_len1,
   input  logic                cal_wr_en,
   input  logic                cal_wr_sel,
   input  logic [AW-1:0]       cal_wr_addr,
   input  logic [PORT_W-1:0]   cal_wr_port,
   input  logic [2*NPORTS-1:0] port_status,
   output logic [1:0]          stat_out
);
   if ((1 << PORT_W) != NPORTS || NPORTS < 2) begin : g_bad_ports
      $error("NPORTS must be a power of two, at least 2");
   end
   if ((1 << AW) != CAL_DEPTH || CAL_DEPTH < 2) begin : g_bad_depth
      $error("CAL_DEPTH must be a power of two, at least 2");
   end
   if (TRAIN_HALF < 1) begin : g_bad_train
      $error("TRAIN_HALF must be at least 1");
   end

   fstat_state_e      st;
   logic              train_hi;
   logic [AW-1:0]     idx;
   logic              act_cal;
   logic [PORT_W-1:0] rd_port;
   logic [1:0]        entry_word;
   logic [1:0]        dip;
   logic [1:0]        word;

   fstat_seq #(
      .AW(AW), .INT_W(INT_W), .REP_W(REP_W), .TRAIN_HALF(TRAIN_HALF)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .en(cfg_enable),
      .interval(cfg_interval), .repeat_m1(cfg_repeat),
      .sw_en(cfg_cal_sw_en), .sel(cfg_cal_sel),
      .len0(cfg_len0), .len1(cfg_len1),
      .st(st), .train_hi(train_hi), .idx(idx), .act_cal(act_cal)
   );

   fstat_cal_store #(
      .DEPTH(CAL_DEPTH), .PORT_W(PORT_W), .AW(AW)
   ) u_cal (
      .clk(clk), .wr_en(cal_wr_en), .wr_sel(cal_wr_sel),
      .wr_addr(cal_wr_addr), .wr_port(cal_wr_port),
      .rd_sel(act_cal), .rd_addr(idx), .rd_port(rd_port)
   );

   assign entry_word = port_status[{rd_port, 1'b0} +: 2];

   fstat_parity #(.ODD(ODD_DIP)) u_par (
      .clk(clk), .rst_n(rst_n),
      .clr(st == S_FRAME), .add(st == S_ENTRY),
      .word_in(entry_word), .dip(dip)
   );

   always_comb begin
      unique case (st)
         S_TRAIN: word = train_hi ? FRAME_CODE : TRAIN_LO;
         S_ENTRY: word = entry_word;
         S_DIP:   word = dip;
         default: word = FRAME_CODE;
      endcase
   end

   assign stat_out = word;

   // R1
   idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_OFF) |-> (stat_out == FRAME_CODE));
endmodule

// File: tb/fstat_sched_bench.sv
module fstat_sched_bench;
   localparam int NP = 16;
   localparam int DEPTH = 256;
   localparam int PW = 4;
   localparam int AW = 8;
   localparam int TH = 10;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, en, sw_en, sel, we, wsel;
   logic [23:0]   interval;
   logic [7:0]    alpha;
   logic [AW-1:0] len0, len1, waddr;
   logic [PW-1:0] wport;
   logic [2*NP-1:0] ps;
   logic [1:0]    so;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int cal_m [2][DEPTH];
   int m_mode, m_rep, m_w, m_idx, m_pass, m_cal, m_len, m_acc;

   fstat_sched u_fstat_sched (
      .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_interval(interval),
      .cfg_repeat(alpha), .cfg_cal_sw_en(sw_en), .cfg_cal_sel(sel),
      .cfg_len0(len0), .cfg_len1(len1), .cal_wr_en(we), .cal_wr_sel(wsel),
      .cal_wr_addr(waddr), .cal_wr_port(wport), .port_status(ps),
      .stat_out(so)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   function automatic int port_word(input int p);
      return int'((ps >> (2 * p)) & 32'd3);
   endfunction

   // Reference model: modes 0 idle, 1 training, 2 framing, 3 entry, 4 parity.
   task automatic step();
      int w;
      #1;
      case (m_mode)
         0: check("R1 R9 idle", int'(so), 3);
         1: check("R2 R8 training", int'(so), (m_w < TH) ? 3 : 0);
         2: check("R3 R8 R9 frame", int'(so), 3);
         3: begin
            w = port_word(cal_m[m_cal][m_idx]);
            check("R4 R6 R7 R10 entry", int'(so), w);
         end
         default: check("R5 parity", int'(so), (~m_acc) & 3);
      endcase
      if (!en) begin
         m_mode = 0;
         m_pass = 0;
      end else begin
         case (m_mode)
            0: begin m_mode = 1; m_rep = 0; m_w = 0; end
            1: begin
               if (m_w == 2 * TH - 1) begin
                  m_w = 0;
                  if (m_rep >= int'(alpha)) m_mode = 2;
                  else m_rep++;
               end else m_w++;
            end
            2: begin
               m_cal = (sw_en && sel) ? 1 : 0;
               m_len = m_cal ? int'(len1) : int'(len0);
               m_acc = 0;
               m_idx = 0;
               m_mode = 3;
            end
            3: begin
               m_acc = m_acc ^ port_word(cal_m[m_cal][m_idx]);
               if (m_idx == m_len) m_mode = 4;
               else m_idx++;
            end
            default: begin
               if (interval == 0) begin
                  m_pass = 0; m_mode = 2;
               end else if (m_pass + 1 >= int'(interval)) begin
                  m_pass = 0; m_mode = 1; m_rep = 0; m_w = 0;
               end else begin
                  m_pass++; m_mode = 2;
               end
            end
         endcase
      end
      if (we) cal_m[wsel][waddr] = int'(wport);
      @(negedge clk);
      cyc++;
      we = 1'b0;
   endtask

   task automatic phase(input int n, input int off_odds, input bit rnd_cfg,
                        input int tog_odds);
      for (int i = 0; i < n; i++) begin
         ps = 32'($urandom);
         if (!en && ($urandom % 20 == 0)) en = 1'b1;
         else if (en && off_odds > 0 && ($urandom % off_odds == 0)) en = 1'b0;
         if (tog_odds > 0 && ($urandom % tog_odds == 0)) sw_en = ~sw_en;
         if (tog_odds > 0 && ($urandom % tog_odds == 0)) sel = ~sel;
         if (rnd_cfg && ($urandom % 150 == 0)) begin
            interval = 24'($urandom % 4);
            alpha    = 8'($urandom % 3);
            len0     = AW'($urandom % 8);
            len1     = AW'($urandom % 8);
         end
         if (rnd_cfg && ($urandom % 10 == 0)) begin
            we = 1'b1; wsel = 1'($urandom);
            waddr = AW'($urandom % 8); wport = PW'($urandom);
         end
         step();
      end
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5eed_0042);
      rst_n = 1'b0; en = 1'b0; sw_en = 1'b0; sel = 1'b0; we = 1'b0;
      wsel = 1'b0; waddr = '0; wport = '0; interval = '0; alpha = '0;
      len0 = '0; len1 = '0; ps = '0;
      m_mode = 0; m_rep = 0; m_w = 0; m_idx = 0; m_pass = 0;
      m_cal = 0; m_len = 0; m_acc = 0;
      repeat (3) @(negedge clk);
      check("R1 reset", int'(so), 3);
      rst_n = 1'b1;
      // Load both calendars while idle (R1 checked each cycle).
      for (int c = 0; c < 2; c++) begin
         for (int a = 0; a < DEPTH; a++) begin
            we = 1'b1; wsel = c[0]; waddr = AW'(a); wport = PW'($urandom);
            step();
         end
      end
      // R6: switching disabled, select ignored.
      en = 1'b1; sel = 1'b1; sw_en = 1'b0; len0 = 8'd3; len1 = 8'd5;
      interval = 24'd2; alpha = 8'd1;
      phase(600, 0, 1'b0, 0);
      // R6: calendar 1 selected.
      sw_en = 1'b1;
      phase(400, 0, 1'b0, 0);
      // R7 R8 R9: random switching, config and enable drops.
      phase(20000, 400, 1'b1, 30);
      // R10: full-length calendars.
      en = 1'b1; len0 = 8'd255; len1 = 8'd255; interval = 24'd1; alpha = 8'd0;
      phase(3000, 0, 1'b0, 200);
      // R2 R8: longest burst, then no periodic training.
      en = 1'b0; step();
      en = 1'b1; len0 = 8'd2; len1 = 8'd1; interval = 24'd0; alpha = 8'd255;
      phase(6000, 0, 1'b0, 0);
      // R9: frequent enable drops.
      interval = 24'd1; alpha = 8'd0;
      phase(3000, 15, 1'b0, 40);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule